// File: doc/BRIEF.md
# NAT64 Transport Checksum Fixup (IPv6 to IPv4)

When a TCP segment or UDP datagram is translated from IPv6 to IPv4, its transport checksum still covers the IPv6 pseudo header. This block produces the checksum the IPv4 packet must carry, and it never reads the payload. Translation logic upstream hands it the original checksum together with the IPv6 and the IPv4 pseudo-header fields. The block sums each pseudo header with one's complement arithmetic, removes the IPv6 contribution from the checksum and adds the IPv4 contribution in its place.

The IPv6 pseudo header contributes 19 words. Each of the two 128-bit addresses gives eight 16-bit words, the 32-bit upper-layer length gives two words, and the next-header byte, zero-extended, gives one word. The IPv4 pseudo header contributes 6 words: two words from each 32-bit address, the protocol byte zero-extended to a word, and the 16-bit length. The result is `~(~old + ~sum6 + sum4)`. Every addition wraps its carry out of bit 15 back into bit 0.

Requests arrive on a valid/ready handshake and results leave on a second one. The datapath has two register stages and accepts one request per cycle. A stalled output holds its result and pushes back towards the input.

Top module: `nat64_csum_adj`

## Requirements
- R1: While reset is asserted and right after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: With `in_is_udp`=0, `out_csum` equals the checksum computed in full over the IPv4 pseudo header and the payload, where the incoming checksum was the full checksum over the IPv6 pseudo header and the same payload.
- R3: With `in_is_udp`=1 and a nonzero incoming checksum, `out_csum` equals the full IPv4-side checksum, as in R2.
- R4: With `in_is_udp`=1 and an incoming checksum of 0x0000 (no checksum present), `out_csum` is 0x0000.
- R5: When the corrected checksum computes to 0x0000, the block sends 0xFFFF for UDP (`in_is_udp`=1) and 0x0000 for TCP (`in_is_udp`=0).
- R6: End-around carries are handled for every operand: all-ones addresses, lengths, protocol and payload still give the full-recompute value.
- R7: A request accepted at a rising edge (`in_valid` and `in_ready` both 1) sets `out_valid` at the next rising edge. Back-to-back requests come out on consecutive cycles in the order they were accepted.
- R8: While `out_valid`=1 and `out_ready`=0, `out_csum` holds its value. With both stages full, `in_ready` is 0. No result is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_is_udp | input | 1 | 1 = UDP rules apply, 0 = TCP |
| in_old_csum | input | 16 | Transport checksum as carried in the IPv6 packet |
| in_v6_src | input | 128 | IPv6 source address |
| in_v6_dst | input | 128 | IPv6 destination address |
| in_v6_len | input | 32 | IPv6 pseudo-header upper-layer length |
| in_v6_nh | input | 8 | IPv6 pseudo-header next-header value |
| in_v4_src | input | 32 | IPv4 source address |
| in_v4_dst | input | 32 | IPv4 destination address |
| in_v4_proto | input | 8 | IPv4 pseudo-header protocol |
| in_v4_len | input | 16 | IPv4 pseudo-header length |
| out_valid | output | 1 | Corrected checksum present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_csum | output | 16 | Corrected transport checksum |

## Verification
The bench uses a payload crafted so that the IPv4-side sum lands exactly on 0xFFFF. There a design that skips the UDP zero substitution sends 0x0000, which means "no checksum". A design that applies the substitution to TCP as well sends 0xFFFF. The bench also sends all-ones operands to catch an adder that drops the end-around carry, which leaves results one off, and a UDP request with a zero checksum, which a careless design would rewrite. It stalls the output with two requests in flight, so that a pipeline that overwrites or repeats a result, or that keeps `in_ready` high while full, shows up as a wrong sequence.

// File: rtl/nat64_csum_pkg.sv
package nat64_csum_pkg;
  localparam int unsigned CSUM_W = 16;

  typedef logic [CSUM_W-1:0] word_t;

  // One's complement add; a single wrap suffices for two 16-bit operands
  function automatic word_t oc_add(input word_t a, input word_t b);
    logic [CSUM_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[CSUM_W-1:0] + {{(CSUM_W-1){1'b0}}, s[CSUM_W]};
  endfunction

  // Incremental fixup: ~(~old + ~sum6 + sum4)
  function automatic word_t oc_fix(input word_t old, input word_t sum6, input word_t sum4);
    return ~oc_add(oc_add(~old, ~sum6), sum4);
  endfunction
endpackage

// File: rtl/csum_chain.sv
module csum_chain
  import nat64_csum_pkg::*;
#(
  parameter int unsigned N_WORDS = 6
) (
  input  logic [N_WORDS*CSUM_W-1:0] words,
  output word_t                     sum
);
  word_t acc [0:N_WORDS];

  assign acc[0] = '0;

  for (genvar i = 0; i < N_WORDS; i++) begin : g_add
    assign acc[i+1] = oc_add(acc[i], words[i*CSUM_W +: CSUM_W]);
  end

  assign sum = acc[N_WORDS];
endmodule

// File: rtl/csum_fixup.sv
module csum_fixup
  import nat64_csum_pkg::*;
(
  input  logic  is_udp,
  input  word_t old_csum,
  input  word_t sum6,
  input  word_t sum4,
  output word_t new_csum,
  output logic  bypass
);
  word_t raw;

  assign bypass = is_udp && (old_csum == '0);
  assign raw    = oc_fix(old_csum, sum6, sum4);

  always_comb begin
    if (bypass)                      new_csum = '0;
    else if (is_udp && raw == '0)    new_csum = '1;
    else                             new_csum = raw;
  end
endmodule

// File: rtl/nat64_csum_adj.sv
module nat64_csum_adj
  import nat64_csum_pkg::*;
#(
  parameter int unsigned ADDR6_W = 128,
  parameter int unsigned ADDR4_W = 32,
  parameter int unsigned LEN6_W  = 32,
  parameter int unsigned PROTO_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 in_is_udp,
  input  logic [CSUM_W-1:0]    in_old_csum,
  input  logic [ADDR6_W-1:0]   in_v6_src,
  input  logic [ADDR6_W-1:0]   in_v6_dst,
  input  logic [LEN6_W-1:0]    in_v6_len,
  input  logic [PROTO_W-1:0]   in_v6_nh,
  input  logic [ADDR4_W-1:0]   in_v4_src,
  input  logic [ADDR4_W-1:0]   in_v4_dst,
  input  logic [PROTO_W-1:0]   in_v4_proto,
  input  logic [CSUM_W-1:0]    in_v4_len,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [CSUM_W-1:0]    out_csum
);
  localparam int unsigned PAD_W    = CSUM_W - PROTO_W;
  localparam int unsigned V6_BITS  = 2*ADDR6_W + LEN6_W + CSUM_W;
  localparam int unsigned V4_BITS  = 2*ADDR4_W + 2*CSUM_W;
  localparam int unsigned V6_WORDS = V6_BITS / CSUM_W;
  localparam int unsigned V4_WORDS = V4_BITS / CSUM_W;

  // stage 1: pseudo-header sums
  logic  s1_valid, s1_adv, s1_udp;
  word_t s1_old, s1_sum6, s1_sum4;
  // stage 2 (output): corrected checksum
  logic  s2_adv, s2_udp, s2_bypass;

  word_t sum6_c, sum4_c, fix_c;
  logic  bypass_c;

  logic [V6_BITS-1:0] v6_words;
  logic [V4_BITS-1:0] v4_words;

  assign v6_words = {in_v6_src, in_v6_dst, in_v6_len, {PAD_W{1'b0}}, in_v6_nh};
  assign v4_words = {in_v4_src, in_v4_dst, {PAD_W{1'b0}}, in_v4_proto, in_v4_len};

  csum_chain #(.N_WORDS(V6_WORDS)) u_sum6 (.words(v6_words), .sum(sum6_c));
  csum_chain #(.N_WORDS(V4_WORDS)) u_sum4 (.words(v4_words), .sum(sum4_c));

  assign s2_adv   = !out_valid || out_ready;
  assign s1_adv   = !s1_valid || s2_adv;
  assign in_ready = s1_adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_udp   <= 1'b0;
      s1_old   <= '0;
      s1_sum6  <= '0;
      s1_sum4  <= '0;
    end else if (s1_adv) begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_udp  <= in_is_udp;
        s1_old  <= in_old_csum;
        s1_sum6 <= sum6_c;
        s1_sum4 <= sum4_c;
      end
    end
  end

  csum_fixup u_fix (
    .is_udp  (s1_udp),
    .old_csum(s1_old),
    .sum6    (s1_sum6),
    .sum4    (s1_sum4),
    .new_csum(fix_c),
    .bypass  (bypass_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_csum  <= '0;
      s2_udp    <= 1'b0;
      s2_bypass <= 1'b0;
    end else if (s2_adv) begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_csum  <= fix_c;
        s2_udp    <= s1_udp;
        s2_bypass <= bypass_c;
      end
    end
  end
endmodule

// File: rtl/nat64_csum_adj_chk.sv
module nat64_csum_adj_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [15:0] out_csum,
  input logic        s1_valid,
  input logic        res_udp,
  input logic        res_bypass
);
  p_reset_r1: assert property (@(posedge clk) !rst_n |-> !out_valid);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_csum));

  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid && !in_ready |=> s1_valid);

  p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> s1_valid);

  p_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && res_bypass |-> out_csum == 16'h0000);

  p_udp_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && res_udp && !res_bypass |-> out_csum != 16'h0000);
endmodule

bind nat64_csum_adj nat64_csum_adj_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_csum  (out_csum),
  .s1_valid  (s1_valid),
  .res_udp   (s2_udp),
  .res_bypass(s2_bypass)
);

// File: tb/sim_nat64_csum_adj.sv
module sim_nat64_csum_adj;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic         in_is_udp = 1'b0;
  logic [15:0]  in_old_csum = '0;
  logic [127:0] in_v6_src = '0, in_v6_dst = '0;
  logic [31:0]  in_v6_len = '0;
  logic [7:0]   in_v6_nh = '0;
  logic [31:0]  in_v4_src = '0, in_v4_dst = '0;
  logic [7:0]   in_v4_proto = '0;
  logic [15:0]  in_v4_len = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [15:0]  out_csum;

  int n_checks = 0;
  int n_errs   = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  nat64_csum_adj u0 (.*);

  typedef struct {
    logic         udp;
    logic [127:0] s6, d6;
    logic [31:0]  len6;
    logic [7:0]   nh;
    logic [31:0]  s4, d4;
    logic [7:0]   proto;
    logic [15:0]  len4;
    logic [15:0]  pay [16];
    int           npay;
    logic [15:0]  old;
    logic [15:0]  exp;
  } req_t;

  function automatic logic [15:0] fold32(input logic [31:0] a);
    logic [31:0] t = a;
    while (t[31:16] != 0) t = {16'h0, t[15:0]} + {16'h0, t[31:16]};
    return t[15:0];
  endfunction

  function automatic logic [31:0] hdr6(input req_t r);
    logic [31:0] a = 0;
    for (int i = 0; i < 8; i++) a += r.s6[i*16 +: 16] + r.d6[i*16 +: 16];
    a += r.len6[31:16] + r.len6[15:0] + r.nh;
    return a;
  endfunction

  function automatic logic [31:0] hdr4(input req_t r);
    return r.s4[31:16] + r.s4[15:0] + r.d4[31:16] + r.d4[15:0] + r.proto + r.len4;
  endfunction

  function automatic logic [31:0] paysum(input req_t r, input int upto);
    logic [31:0] a = 0;
    for (int i = 0; i < upto; i++) a += r.pay[i];
    return a;
  endfunction

  function automatic logic [15:0] wire_csum(input logic [31:0] total, input logic udp);
    logic [15:0] c = ~fold32(total);
    if (udp && c == 16'h0) c = 16'hFFFF;
    return c;
  endfunction

  // fill derived fields; make_zero forces the IPv4-side checksum to compute to zero
  function automatic req_t finish(input req_t r0, input bit make_zero);
    req_t r = r0;
    if (make_zero) r.pay[r.npay-1] = ~fold32(hdr4(r) + paysum(r, r.npay-1));
    r.old = wire_csum(hdr6(r) + paysum(r, r.npay), r.udp);
    r.exp = wire_csum(hdr4(r) + paysum(r, r.npay), r.udp);
    return r;
  endfunction

  function automatic req_t rnd_req(input logic udp);
    req_t r;
    r.udp = udp;
    r.s6 = {$urandom, $urandom, $urandom, $urandom};
    r.d6 = {$urandom, $urandom, $urandom, $urandom};
    r.s4 = $urandom | 32'h0100_0000;
    r.d4 = $urandom | 32'h0100_0000;
    r.npay = 4 + ($urandom % 12);
    for (int i = 0; i < 16; i++) r.pay[i] = (i < r.npay) ? 16'($urandom) : 16'h0;
    r.len4 = 16'(r.npay * 2 + (udp ? 8 : 20));
    r.len6 = {16'h0, r.len4};
    r.nh = udp ? 8'd17 : 8'd6;
    r.proto = r.nh;
    return finish(r, 1'b0);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // caller is at a negedge; returns at a negedge after acceptance
  task automatic push(input req_t r);
    in_is_udp = r.udp; in_old_csum = r.old;
    in_v6_src = r.s6; in_v6_dst = r.d6; in_v6_len = r.len6; in_v6_nh = r.nh;
    in_v4_src = r.s4; in_v4_dst = r.d4; in_v4_proto = r.proto; in_v4_len = r.len4;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pop(output logic [15:0] v);
    out_ready = 1'b1;
    while (!out_valid) @(negedge clk);
    v = out_csum;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic run_one(input req_t r, input string tag);
    logic [15:0] v;
    out_ready = 1'b0;
    push(r);
    pop(v);
    chk(v == r.exp, tag, v, r.exp);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid in reset", 16'(out_valid), 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", 16'(out_valid), 16'h0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", 16'(in_ready), 16'h1);
  endtask

  task automatic t_tcp();
    for (int k = 0; k < 6; k++) run_one(rnd_req(1'b0), "R2 tcp random");
  endtask

  task automatic t_udp();
    for (int k = 0; k < 6; k++) begin
      req_t r = rnd_req(1'b1);
      run_one(r, "R3 udp random");
    end
  endtask

  task automatic t_udp_nocsum();
    req_t r = rnd_req(1'b1);
    r.old = 16'h0000;
    r.exp = 16'h0000;
    run_one(r, "R4 udp zero passthrough");
  endtask

  task automatic t_zero_result();
    req_t r = finish(rnd_req(1'b0), 1'b1);
    chk(r.exp == 16'h0000, "R5 tcp zero setup", r.exp, 16'h0000);
    run_one(r, "R5 tcp zero result");
    r = finish(rnd_req(1'b1), 1'b1);
    chk(r.exp == 16'hFFFF, "R5 udp zero setup", r.exp, 16'hFFFF);
    run_one(r, "R5 udp zero sent as FFFF");
  endtask

  task automatic t_allones();
    req_t r = rnd_req(1'b0);
    r.s6 = '1; r.d6 = '1; r.len6 = '1; r.nh = '1;
    r.s4 = '1; r.d4 = '1; r.proto = '1; r.len4 = '1;
    for (int i = 0; i < r.npay; i++) r.pay[i] = 16'hFFFF;
    run_one(finish(r, 1'b0), "R6 all ones tcp");
    r.udp = 1'b1;
    r.s6 = {4{32'hFFFF_0001}};
    run_one(finish(r, 1'b0), "R6 mixed carries udp");
  endtask

  task automatic t_latency();
    req_t a = rnd_req(1'b0);
    req_t b = rnd_req(1'b1);
    out_ready = 1'b1;
    push(a);  // now one negedge after acceptance edge
    chk(out_valid == 1'b0, "R7 not valid before second edge", 16'(out_valid), 16'h0);
    in_is_udp = b.udp; in_old_csum = b.old;
    in_v6_src = b.s6; in_v6_dst = b.d6; in_v6_len = b.len6; in_v6_nh = b.nh;
    in_v4_src = b.s4; in_v4_dst = b.d4; in_v4_proto = b.proto; in_v4_len = b.len4;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R7 valid after second edge", 16'(out_valid), 16'h1);
    chk(out_csum == a.exp, "R7 first result", out_csum, a.exp);
    @(negedge clk);
    chk(out_valid == 1'b1, "R7 back-to-back valid", 16'(out_valid), 16'h1);
    chk(out_csum == b.exp, "R7 second result", out_csum, b.exp);
    @(negedge clk);
    chk(out_valid == 1'b0, "R7 drained", 16'(out_valid), 16'h0);
    out_ready = 1'b0;
  endtask

  task automatic t_backpressure();
    req_t a = rnd_req(1'b1);
    req_t b = rnd_req(1'b0);
    req_t c = rnd_req(1'b1);
    logic [15:0] v;
    out_ready = 1'b0;
    push(a);
    push(b);
    chk(in_ready == 1'b0, "R8 full pipe blocks input", 16'(in_ready), 16'h0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(out_valid && out_csum == a.exp, "R8 held under stall", out_csum, a.exp);
    end
    pop(v);
    chk(v == a.exp, "R8 first after stall", v, a.exp);
    push(c);
    pop(v);
    chk(v == b.exp, "R8 second in order", v, b.exp);
    pop(v);
    chk(v == c.exp, "R8 third in order", v, c.exp);
    chk(out_valid == 1'b0, "R8 no duplicate", 16'(out_valid), 16'h0);
  endtask

  initial begin
    t_reset();
    t_tcp();
    t_udp();
    t_udp_nocsum();
    t_zero_result();
    t_allones();
    t_latency();
    t_backpressure();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end
endmodule